// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a single-port synchronous static RAM. Its bus can flip between reads and writes on consecutive cycles with no idle slot. Every command is sampled on a rising clock edge with the clock enable active. Its data transfer happens exactly two enabled edges later, in both directions:

- A write takes its data from `din` on that edge.
- A read puts the stored word on `dout` from that edge on.

Because both directions share the same two-edge spacing, a read slot and a write slot never collide. A controller may therefore issue any mix of commands back to back.

A command is one of two kinds:

- **Load** (`adv_ld` low): starts a new operation at `addr`, provided all three chip enables are asserted.
- **Advance** (`adv_ld` high): steps an open four-beat burst. Its direction was fixed at the load.

The burst order is chosen at the load, either linear (wrapping add) or interleaved (XOR). Per-byte write strobes allow partial writes. A clock enable freezes the whole pipeline. An asynchronous output enable can turn the output driver off at any moment. Data uses separate `din`, `dout` and `dout_en` ports instead of a tri-state bus.

The burst sequencer has three states:

- `SEQ_IDLE`: no burst open.
- `SEQ_READ`: a read burst is open.
- `SEQ_WRITE`: a write burst is open.

Its transitions, applied on each enabled edge:

- **load-read**: any state to `SEQ_READ`, on a selected load with `rd_nwr` high.
- **load-write**: any state to `SEQ_WRITE`, on a selected load with `rd_nwr` low.
- **deselect**: any state to `SEQ_IDLE`, on a load with any chip enable inactive.
- **advance**: `SEQ_READ` or `SEQ_WRITE` stays in place and steps the beat counter.
- **idle-hold**: an advance in `SEQ_IDLE` stays in `SEQ_IDLE` and starts nothing.

Top module: `zbt_sram`

## Requirements
- R1: A read command sampled on enabled edge k updates `dout` to the addressed word on enabled edge k+2. From then on `dout_en` is high while `oe_n` is low. `dout` keeps its last read value until the next read slot.
- R2: Reads and writes may be issued on consecutive enabled cycles in any mix with no idle cycle. A read issued on the cycle right after a write to the same address returns the newly written data.
- R3: While `cen_n` is high, all other synchronous inputs are ignored. The sequencer and both pipeline stages hold, pending transfers included, and `dout` stays unchanged.
- R4: A load starts an operation only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise it starts nothing and writes nothing, but transfers already in the pipeline still complete.
- R5: A deselecting load or a write command sampled on enabled edge k forces `dout_en` low from enabled edge k+2.
- R6: `oe_n` high forces `dout_en` low at once, without waiting for a clock edge.
- R7: `bwe_n[i]` (active low) is sampled with the write command. Its lane `din[8i+7:8i]` is written into the word; a lane whose strobe is high keeps its old byte.
- R8: The low two address bits of beat j of a burst (j = 0..3, wrapping to 0 after 3) follow the order picked at the load:
  - `order_lin`=1 (linear): (base + j) mod 4.
  - `order_lin`=0 (interleaved): base XOR j.
  The upper address bits stay at the loaded value. `rd_nwr` is ignored on advance cycles.
- R9: A rising edge with `rst_n` low empties the pipeline, returns the sequencer to `SEQ_IDLE`, clears `dout` to 0 and leaves `dout_en` low. The array contents are not cleared.
- R10: An advance command while no burst is open (after reset or a deselect) starts no operation and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low; high freezes the block |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| rd_nwr | input | 1 | 1 = read, 0 = write; sampled on loads only |
| order_lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| bwe_n | input | NB | Per-byte write strobes, active low |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | NB*BW | Write data, sampled two enabled edges after its command |
| dout | output | NB*BW | Read data register |
| dout_en | output | 1 | Output driver enable |

## Verification
The checker watches, on every cycle, four port-level rules:
- the output-enable gate;
- `dout` holding while the clock enable is high;
- the driver being on exactly two enabled edges after a selected read load;
- the driver being off two enabled edges after a write or deselect, and after reset.

Data correctness is shown only by the bench's scenarios, which compare every cycle against a reference model of the array and the pipeline. This covers:
- write-then-read forwarding;
- byte-lane merging;
- linear and interleaved beat addresses;
- loads that are ignored for lack of chip select;
- advances with no burst open.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;

    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;

    // low address bits for a given beat of a burst
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] base,
        input logic [BEAT_W-1:0] beat,
        input logic              linear
    );
        if (linear)
            return BEAT_W'(base + beat);
        else
            return base ^ beat;
    endfunction

endpackage

// File: rtl/zbt_seq.sv
`timescale 1ns/1ps
module zbt_seq
    import zbt_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          load,
    input  logic          sel,
    input  logic          rd,
    input  logic          lin,
    input  logic [AW-1:0] addr,
    output logic          cmd_vld,
    output logic          cmd_wr,
    output logic [AW-1:0] cmd_addr
);

    seq_state_e        state_q, state_nx;
    logic [AW-1:0]     base_q, base_nx;
    logic [BEAT_W-1:0] beat_q, beat_nx;
    logic              lin_q, lin_nx;
    logic [BEAT_W-1:0] beat_inc;

    assign beat_inc = BEAT_W'(beat_q + 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            lin_q   <= 1'b1;
        end else if (step_en) begin
            state_q <= state_nx;
            base_q  <= base_nx;
            beat_q  <= beat_nx;
            lin_q   <= lin_nx;
        end
    end

    // next state and command outputs
    always_comb begin
        state_nx = state_q;
        base_nx  = base_q;
        beat_nx  = beat_q;
        lin_nx   = lin_q;
        cmd_vld  = 1'b0;
        cmd_wr   = 1'b0;
        cmd_addr = addr;
        if (load) begin
            if (sel) begin
                // load-read / load-write
                state_nx = rd ? SEQ_READ : SEQ_WRITE;
                base_nx  = addr;
                beat_nx  = '0;
                lin_nx   = lin;
                cmd_vld  = 1'b1;
                cmd_wr   = !rd;
                cmd_addr = addr;
            end else begin
                // deselect
                state_nx = SEQ_IDLE;
            end
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    // idle-hold: advance with no open burst
                    state_nx = SEQ_IDLE;
                end
                SEQ_READ, SEQ_WRITE: begin
                    // advance
                    beat_nx  = beat_inc;
                    cmd_vld  = 1'b1;
                    cmd_wr   = (state_q == SEQ_WRITE);
                    cmd_addr = {base_q[AW-1:BEAT_W],
                                beat_low(base_q[BEAT_W-1:0], beat_inc, lin_q)};
                end
                default: state_nx = SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/zbt_pipe.sv
`timescale 1ns/1ps
module zbt_pipe #(
    parameter int AW     = 6,
    parameter int NB     = 4,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          in_vld,
    input  logic          in_wr,
    input  logic [AW-1:0] in_addr,
    input  logic [NB-1:0] in_bwe_n,
    output logic          out_vld,
    output logic          out_wr,
    output logic [AW-1:0] out_addr,
    output logic [NB-1:0] out_bwe_n
);

    logic          vld_q  [STAGES];
    logic          wr_q   [STAGES];
    logic [AW-1:0] addr_q [STAGES];
    logic [NB-1:0] bwe_q  [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld_q[0] <= 1'b0;
                        wr_q[0]  <= 1'b0;
                        addr_q[0] <= '0;
                        bwe_q[0] <= '1;
                    end else if (step_en) begin
                        vld_q[0] <= in_vld;
                        wr_q[0]  <= in_wr;
                        addr_q[0] <= in_addr;
                        bwe_q[0] <= in_bwe_n;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld_q[s] <= 1'b0;
                        wr_q[s]  <= 1'b0;
                        addr_q[s] <= '0;
                        bwe_q[s] <= '1;
                    end else if (step_en) begin
                        vld_q[s] <= vld_q[s-1];
                        wr_q[s]  <= wr_q[s-1];
                        addr_q[s] <= addr_q[s-1];
                        bwe_q[s] <= bwe_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign out_vld   = vld_q[STAGES-1];
    assign out_wr    = wr_q[STAGES-1];
    assign out_addr  = addr_q[STAGES-1];
    assign out_bwe_n = bwe_q[STAGES-1];

endmodule

// File: rtl/zbt_mem.sv
`timescale 1ns/1ps
module zbt_mem #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             op_vld,
    input  logic             op_wr,
    input  logic [AW-1:0]    op_addr,
    input  logic [NB-1:0]    op_bwe_n,
    input  logic [NB*BW-1:0] wdata,
    output logic [NB*BW-1:0] rdata_q,
    output logic             drive_q
);

    localparam int DEPTH = 1 << AW;
    localparam int DW    = NB * BW;

    logic [DW-1:0] rd_word;
    logic          do_read;

    assign do_read = op_vld && !op_wr;

    genvar l;
    generate
        for (l = 0; l < NB; l++) begin : g_lane
            logic [BW-1:0] lane_mem [DEPTH];
            always_ff @(posedge clk) begin
                if (rst_n && step_en && op_vld && op_wr && !op_bwe_n[l])
                    lane_mem[op_addr] <= wdata[l*BW +: BW];
            end
            assign rd_word[l*BW +: BW] = lane_mem[op_addr];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            drive_q <= 1'b0;
        end else if (step_en) begin
            drive_q <= do_read;
            if (do_read)
                rdata_q <= rd_word;
        end
    end

endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cen_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             adv_ld,
    input  logic             rd_nwr,
    input  logic             order_lin,
    input  logic [NB-1:0]    bwe_n,
    input  logic [AW-1:0]    addr,
    input  logic             oe_n,
    input  logic [NB*BW-1:0] din,
    output logic [NB*BW-1:0] dout,
    output logic             dout_en
);

    logic          step_en, chip_sel;
    logic          c_vld, c_wr;
    logic [AW-1:0] c_addr;
    logic          d_vld, d_wr;
    logic [AW-1:0] d_addr;
    logic [NB-1:0] d_bwe_n;
    logic          drive_q;

    assign step_en  = !cen_n;
    assign chip_sel = !ce1_n && ce2 && !ce3_n;

    zbt_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .load     (!adv_ld),
        .sel      (chip_sel),
        .rd       (rd_nwr),
        .lin      (order_lin),
        .addr     (addr),
        .cmd_vld  (c_vld),
        .cmd_wr   (c_wr),
        .cmd_addr (c_addr)
    );

    zbt_pipe #(.AW(AW), .NB(NB), .STAGES(2)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .in_vld    (c_vld),
        .in_wr     (c_wr),
        .in_addr   (c_addr),
        .in_bwe_n  (bwe_n),
        .out_vld   (d_vld),
        .out_wr    (d_wr),
        .out_addr  (d_addr),
        .out_bwe_n (d_bwe_n)
    );

    zbt_mem #(.AW(AW), .NB(NB), .BW(BW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .op_vld   (d_vld),
        .op_wr    (d_wr),
        .op_addr  (d_addr),
        .op_bwe_n (d_bwe_n),
        .wdata    (din),
        .rdata_q  (dout),
        .drive_q  (drive_q)
    );

    assign dout_en = drive_q && !oe_n;

endmodule

// File: rtl/zbt_sram_chk.sv
`timescale 1ns/1ps
module zbt_sram_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cen_n,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          adv_ld,
    input logic          rd_nwr,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          dout_en
);

    logic sel_all;
    assign sel_all = !ce1_n && ce2 && !ce3_n;

    // R6: output enable overrides the driver
    assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R3: a frozen cycle leaves the read register untouched
    assert_freeze_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(dout));

    // R1: selected read load turns the driver on two enabled edges later
    assert_read_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && sel_all && rd_nwr) ##1 !cen_n ##1 !cen_n
        |=> (dout_en == !oe_n));

    // R5: write or deselect turns the driver off two enabled edges later
    assert_drive_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && (!sel_all || !rd_nwr)) ##1 !cen_n ##1 !cen_n
        |=> !dout_en);

    // R9: reset leaves the driver off
    assert_reset_off_R9: assert property (@(posedge clk)
        !rst_n |=> !dout_en);

endmodule

bind zbt_sram zbt_sram_chk #(.DW(NB*BW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cen_n   (cen_n),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .adv_ld  (adv_ld),
    .rd_nwr  (rd_nwr),
    .oe_n    (oe_n),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int BW = 8;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n, cen_n, ce1_n, ce2, ce3_n, adv_ld, rd_nwr, order_lin, oe_n;
    logic [NB-1:0] bwe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din, dout;
    logic dout_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    zbt_sram #(.AW(AW), .NB(NB), .BW(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_ld(adv_ld), .rd_nwr(rd_nwr), .order_lin(order_lin),
        .bwe_n(bwe_n), .addr(addr), .oe_n(oe_n), .din(din), .dout(dout),
        .dout_en(dout_en)
    );

    // reference model
    logic [DW-1:0] m_mem [DEPTH];
    logic          p_vld [2];
    logic          p_wr  [2];
    logic [AW-1:0] p_addr[2];
    logic [NB-1:0] p_bwe [2];
    int            b_st;
    logic [AW-1:0] b_base;
    logic [1:0]    b_beat;
    logic          b_lin;
    logic          e_drv;
    logic [DW-1:0] e_dout;

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                                 input logic [1:0] j,
                                                 input logic lin);
        logic [1:0] lo;
        lo = lin ? 2'(base[1:0] + j) : (base[1:0] ^ j);
        return {base[AW-1:2], lo};
    endfunction

    task automatic model_edge();
        logic          n_vld, n_wr;
        logic [AW-1:0] n_addr;
        if (!rst_n) begin
            p_vld[0] = 0; p_vld[1] = 0; b_st = 0; b_beat = 0;
            e_drv = 0; e_dout = '0;
        end else if (!cen_n) begin
            if (p_vld[1] && p_wr[1]) begin
                for (int i = 0; i < NB; i++)
                    if (!p_bwe[1][i]) m_mem[p_addr[1]][i*BW +: BW] = din[i*BW +: BW];
            end else if (p_vld[1]) begin
                e_dout = m_mem[p_addr[1]];
            end
            e_drv = p_vld[1] && !p_wr[1];
            p_vld[1] = p_vld[0]; p_wr[1] = p_wr[0];
            p_addr[1] = p_addr[0]; p_bwe[1] = p_bwe[0];
            n_vld = 0; n_wr = 0; n_addr = addr;
            if (!adv_ld) begin
                if (!ce1_n && ce2 && !ce3_n) begin
                    n_vld = 1; n_wr = !rd_nwr; n_addr = addr;
                    b_st = rd_nwr ? 1 : 2; b_base = addr; b_beat = 0; b_lin = order_lin;
                end else b_st = 0;
            end else if (b_st != 0) begin
                b_beat = b_beat + 2'd1;
                n_vld = 1; n_wr = (b_st == 2);
                n_addr = beat_addr(b_base, b_beat, b_lin);
            end
            p_vld[0] = n_vld; p_wr[0] = n_wr; p_addr[0] = n_addr; p_bwe[0] = bwe_n;
        end
    endtask

    task automatic chk1(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk1(tag, "dout_en", DW'(dout_en), DW'(e_drv && !oe_n));
        chk1(tag, "dout", dout, e_dout);
    endtask

    task automatic cyc(input string tag, input bit ld, input bit sl, input bit rd,
                       input int a, input logic [NB-1:0] bw, input bit lin);
        adv_ld = !ld; ce1_n = !sl; ce2 = 1; ce3_n = 0; cen_n = 0;
        rd_nwr = rd; addr = AW'(a); bwe_n = bw; order_lin = lin;
        din = $urandom;
        tick(tag);
    endtask

    task automatic desel(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1, 0, 1, 0, '1, 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h2659));
        rst_n = 0; cen_n = 0; ce1_n = 1; ce2 = 1; ce3_n = 0; adv_ld = 0;
        rd_nwr = 1; order_lin = 1; bwe_n = '1; addr = '0; oe_n = 0; din = '0;
        // R9: reset state
        tick("R9"); tick("R9"); tick("R9");
        rst_n = 1;
        desel("R9", 2);

        // R8: fill every word with linear write bursts
        for (int b = 0; b < DEPTH / 4; b++) begin
            cyc("R8", 1, 1, 0, 4 * b, '0, 1);
            for (int j = 0; j < 3; j++) cyc("R8", 0, 0, 1, 0, '0, 0);
        end
        desel("R8", 3);

        // R2: alternating write/read, read right after write to same word
        cyc("R2", 1, 1, 0, 5, '0, 1);
        cyc("R2", 1, 1, 1, 5, '1, 1);
        cyc("R2", 1, 1, 0, 9, '0, 1);
        cyc("R2", 1, 1, 1, 9, '1, 1);
        cyc("R2", 1, 1, 1, 5, '1, 1);
        cyc("R2", 1, 1, 0, 6, '0, 1);
        desel("R2", 3);

        // R1: single read latency
        cyc("R1", 1, 1, 1, 7, '1, 1);
        desel("R1", 3);

        // R7: partial write then readback
        cyc("R7", 1, 1, 0, 10, 4'b1010, 1);
        cyc("R7", 1, 1, 0, 11, 4'b0111, 1);
        cyc("R7", 1, 1, 1, 10, '1, 1);
        cyc("R7", 1, 1, 1, 11, '1, 1);
        desel("R7", 3);

        // R3: freeze with a read in flight
        cyc("R3", 1, 1, 1, 12, '1, 1);
        for (int i = 0; i < 3; i++) begin
            cen_n = 1; adv_ld = 0; ce1_n = 0; rd_nwr = 0; addr = 12; din = $urandom;
            tick("R3");
        end
        desel("R3", 3);
        cyc("R3", 1, 1, 1, 12, '1, 1);
        desel("R3", 3);

        // R4: unselected load is ignored, pending read completes
        cyc("R4", 1, 1, 1, 13, '1, 1);
        adv_ld = 0; ce1_n = 0; ce2 = 1; ce3_n = 1; rd_nwr = 0; addr = 13;
        bwe_n = '0; din = $urandom; tick("R4");
        adv_ld = 0; ce1_n = 0; ce2 = 0; ce3_n = 0; din = $urandom; tick("R4");
        desel("R4", 2);
        cyc("R4", 1, 1, 1, 13, '1, 1);
        desel("R4", 3);

        // R5: a write right after a read turns the driver off in its slot
        cyc("R5", 1, 1, 1, 20, '1, 1);
        cyc("R5", 1, 1, 0, 21, '0, 1);
        cyc("R5", 1, 1, 1, 21, '1, 1);
        desel("R5", 3);

        // R6: asynchronous output enable
        cyc("R6", 1, 1, 1, 22, '1, 1);
        desel("R6", 2);
        oe_n = 1; #2;
        chk1("R6", "dout_en async off", DW'(dout_en), '0);
        oe_n = 0; #2;
        chk1("R6", "dout_en async on", DW'(dout_en), DW'(e_drv));
        desel("R6", 2);

        // R8: interleaved and linear read bursts, rd_nwr toggled on advances
        cyc("R8", 1, 1, 1, 34, '1, 0);
        for (int j = 0; j < 5; j++) cyc("R8", 0, 1, j[0], 0, '0, 1);
        cyc("R8", 1, 1, 1, 41, '1, 0);
        for (int j = 0; j < 3; j++) cyc("R8", 0, 1, 0, 0, '0, 1);
        cyc("R8", 1, 1, 1, 51, '1, 1);
        for (int j = 0; j < 3; j++) cyc("R8", 0, 1, 0, 0, '0, 0);
        cyc("R8", 1, 1, 0, 57, '0, 0);
        for (int j = 0; j < 3; j++) cyc("R8", 0, 1, 1, 0, '0, 1);
        cyc("R8", 1, 1, 1, 57, '1, 0);
        for (int j = 0; j < 3; j++) cyc("R8", 0, 1, 1, 0, '1, 1);
        desel("R8", 3);

        // R10: advance with no burst open writes nothing
        for (int j = 0; j < 4; j++) cyc("R10", 0, 1, 0, 30, '0, 1);
        cyc("R10", 1, 1, 1, 30, '1, 1);
        cyc("R10", 1, 1, 1, 31, '1, 1);
        desel("R10", 3);

        // R2: random mix
        for (int i = 0; i < 3000; i++) begin
            cen_n = ($urandom_range(0, 99) < 15);
            adv_ld = ($urandom_range(0, 99) < 40);
            ce1_n = 0; ce2 = 1; ce3_n = 0;
            if ($urandom_range(0, 99) < 10) begin
                case ($urandom_range(0, 2))
                    0: ce1_n = 1;
                    1: ce2 = 0;
                    default: ce3_n = 1;
                endcase
            end
            rd_nwr = $urandom_range(0, 1);
            order_lin = $urandom_range(0, 1);
            bwe_n = NB'($urandom);
            addr = AW'($urandom);
            oe_n = ($urandom_range(0, 99) < 10);
            din = $urandom;
            tick("R2");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule